// File: doc/BRIEF.md
# Interrupt Vector Priority and Acknowledge Core

This block is the priority engine of a per-processor interrupt controller. It keeps three 256-bit vectors: pending requests, vectors in service and the trigger kind of each vector. It also holds a task priority byte, a spurious-vector register with an enable bit, and an error byte. Requesters deliver one vector per cycle. The core derives the processor priority from the task priority and the highest vector in service. From that it drives a single interrupt line to the CPU. It answers the CPU's acknowledge cycle with a vector, and it retires the top in-service vector when software writes the end-of-interrupt index.

A small state machine sequences the host side. In `ST_IDLE` it takes one command per cycle, with acknowledge first, then a register write, then a register read. An acknowledge moves to `ST_ACK_RESP`, where `ack_valid` and `ack_vector` are shown for one cycle. A read moves to `ST_RD_RESP`, where `reg_rvalid` and `reg_rdata` are shown for one cycle. Both response states go back to `ST_IDLE` on the next edge. Writes finish in `ST_IDLE` and give no response. Host commands sampled in a response state are dropped, so the host issues a new command only after the response has been seen. Vector requests are taken in every state. The interrupt line is combinational from the stored state. It changes right after the edge that updates that state.

A vector's priority class is its upper four bits. Registers are picked by a word index, which is the byte address shifted right by four.

Top module: `vec_prio_core`

## Requirements
- R1: A cycle with `req_valid` high sets the request bit of `req_vector`. It also writes that vector's trigger bit with `req_level` (1 = level, 0 = edge). Both are visible from the next edge.
- R2: The processor priority (index 0x0A, read-only) is computed as follows. Let the in-service class be the upper four bits of the highest in-service vector, or 0 if none. If TPR[7:4] is at least that class, the priority is the full TPR. Otherwise it is the class shifted left by four.
- R3: `cpu_irq` is high exactly when all of these hold: the spurious register bit 8 is set, a request is pending, and either the processor priority is 0 or the class of the highest request exceeds the processor priority class.
- R4: An acknowledge is granted when the enable bit is set, a request is pending, and either TPR is 0 or the highest request vector is above TPR. A granted acknowledge clears that request bit and sets its in-service bit. One edge after `ack_req`, it shows that vector on `ack_vector` with `ack_valid` high.
- R5: Any acknowledge that is not granted returns bits 7:0 of the spurious register and changes no vector bit. This covers the enable bit being clear, no request pending, and TPR nonzero with the highest request at or below TPR.
- R6: A write to index 0x0B clears the highest set in-service bit. If none is set, it does nothing.
- R7: Register layout: TPR at 0x08 (8 bits, read/write); spurious register at 0x0F (writes keep bits 8:0); in-service words 0x10–0x17, trigger words 0x18–0x1F and request words 0x20–0x27. Word k holds vectors 32k+31..32k, with vector 32k at bit 0. Writes to 0x0A, 0x10–0x28 are ignored without error.
- R8: Any read or write to an index not listed in R2, R6 or R7 sets bit 7 of the error byte at 0x28, and that bit stays set until reset. A read of such an index returns 0. A read of 0x0B counts as undefined.
- R9: After reset, TPR, the error byte and all three vectors are 0, the spurious register is 0xFF (controller disabled), and `cpu_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Deliver a vector this cycle |
| req_vector | input | 8 | Vector number being delivered |
| req_level | input | 1 | Trigger kind of the delivered vector, 1 = level |
| ack_req | input | 1 | CPU acknowledge request |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Vector returned to the CPU |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 8 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
The hardest state to reach is nesting. It needs several vectors in service across different classes, a task priority that sits between them, and fresh requests whose class is equal to, just below or just above the processor priority. The directed part builds this on purpose. It acknowledges a low vector and then a higher one, sets TPR above and then below the in-service class, and retires with end-of-interrupt in between. A long random run then mixes requests, acknowledges, retires and priority writes over a narrow band of vectors, so that class collisions and blocked acknowledges happen often. Every response and the interrupt line are compared with a reference model kept in the bench.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    localparam int VEC_W     = 8;
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int DATA_W    = 32;
    localparam int NUM_WORDS = NUM_VEC / DATA_W;
    localparam int WSEL_W    = $clog2(NUM_WORDS);
    localparam int CLS_W     = 4;
    localparam int IX_W      = 8;
    localparam int SVR_W     = VEC_W + 1;
    localparam int ERR_W     = 8;
    localparam int ERR_BIT   = 7;

    localparam logic [IX_W-1:0] IX_TPR = 8'h08;
    localparam logic [IX_W-1:0] IX_PPR = 8'h0A;
    localparam logic [IX_W-1:0] IX_EOI = 8'h0B;
    localparam logic [IX_W-1:0] IX_SVR = 8'h0F;
    localparam logic [IX_W-1:0] IX_ISR = 8'h10;
    localparam logic [IX_W-1:0] IX_TMR = 8'h18;
    localparam logic [IX_W-1:0] IX_IRR = 8'h20;
    localparam logic [IX_W-1:0] IX_ERR = 8'h28;

    localparam logic [SVR_W-1:0] SVR_RST = 9'h0FF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK_RESP,
        ST_RD_RESP
    } ctl_state_e;

    typedef enum logic [2:0] {
        RS_NONE, RS_TPR, RS_PPR, RS_SVR, RS_ISR, RS_TMR, RS_IRR, RS_ERR
    } rd_sel_e;

    typedef enum logic [2:0] {
        WS_BAD, WS_TPR, WS_EOI, WS_SVR, WS_IGN
    } wr_sel_e;

    function automatic logic in_bank(input logic [IX_W-1:0] ix,
                                     input logic [IX_W-1:0] base);
        return ix[IX_W-1:WSEL_W] == base[IX_W-1:WSEL_W];
    endfunction

    function automatic rd_sel_e rd_decode(input logic [IX_W-1:0] ix);
        rd_sel_e s;
        s = RS_NONE;
        if (ix == IX_TPR)              s = RS_TPR;
        else if (ix == IX_PPR)         s = RS_PPR;
        else if (ix == IX_SVR)         s = RS_SVR;
        else if (ix == IX_ERR)         s = RS_ERR;
        else if (in_bank(ix, IX_ISR))  s = RS_ISR;
        else if (in_bank(ix, IX_TMR))  s = RS_TMR;
        else if (in_bank(ix, IX_IRR))  s = RS_IRR;
        return s;
    endfunction

    function automatic wr_sel_e wr_decode(input logic [IX_W-1:0] ix);
        wr_sel_e s;
        s = WS_BAD;
        if (ix == IX_TPR)       s = WS_TPR;
        else if (ix == IX_EOI)  s = WS_EOI;
        else if (ix == IX_SVR)  s = WS_SVR;
        else if (ix == IX_PPR || ix == IX_ERR || in_bank(ix, IX_ISR) ||
                 in_bank(ix, IX_TMR) || in_bank(ix, IX_IRR))
            s = WS_IGN;
        return s;
    endfunction

endpackage

// File: rtl/vpc_top_bit.sv
module vpc_top_bit #(
    parameter int WORDS = 8,
    parameter int WBITS = 32,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BSEL_W = $clog2(WBITS),
    localparam int IDX_W  = WSEL_W + BSEL_W
) (
    input  logic [WORDS*WBITS-1:0] vec,
    output logic [IDX_W-1:0]       idx,
    output logic                   found
);

    logic [WORDS-1:0]  word_nz;
    logic [WSEL_W-1:0] wsel;
    logic [BSEL_W-1:0] bsel;
    logic [WBITS-1:0]  word_sel;

    // first level: one OR-reduce per word
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign word_nz[g] = |vec[g*WBITS +: WBITS];
    end

    // highest non-empty word
    always_comb begin
        wsel = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word_nz[w]) wsel = WSEL_W'(w);
        end
    end

    assign word_sel = vec[int'(wsel)*WBITS +: WBITS];

    // second level: highest bit inside the selected word
    always_comb begin
        bsel = '0;
        for (int b = 0; b < WBITS; b++) begin
            if (word_sel[b]) bsel = BSEL_W'(b);
        end
    end

    assign idx   = {wsel, bsel};
    assign found = |word_nz;

endmodule

// File: rtl/vpc_vec_bank.sv
module vpc_vec_bank #(
    parameter int VEC_W = 8,
    localparam int NUM_VEC = 1 << VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [VEC_W-1:0]   set_idx,
    input  logic               set_level,
    input  logic               move_en,
    input  logic [VEC_W-1:0]   move_idx,
    input  logic               retire_en,
    input  logic [VEC_W-1:0]   retire_idx,
    output logic [NUM_VEC-1:0] irr_q,
    output logic [NUM_VEC-1:0] isr_q,
    output logic [NUM_VEC-1:0] tmr_q
);

    logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;

    // order: acknowledge move, then retire, then new request (request wins)
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        if (move_en) begin
            irr_d[move_idx] = 1'b0;
            isr_d[move_idx] = 1'b1;
        end
        if (retire_en) begin
            isr_d[retire_idx] = 1'b0;
        end
        if (set_en) begin
            irr_d[set_idx] = 1'b1;
            tmr_d[set_idx] = set_level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/vpc_ctrl.sv
module vpc_ctrl
    import vpc_pkg::*;
#(
    parameter int VEC_W     = vpc_pkg::VEC_W,
    parameter int DATA_W    = vpc_pkg::DATA_W,
    parameter int CLS_W     = vpc_pkg::CLS_W,
    localparam int NUM_VEC  = 1 << VEC_W,
    localparam int WORDS    = NUM_VEC / DATA_W,
    localparam int WS_W     = $clog2(WORDS),
    localparam int SV_W     = VEC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_req,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [IX_W-1:0]    reg_idx,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [VEC_W-1:0]   irr_top,
    input  logic               irr_found,
    input  logic [VEC_W-1:0]   isr_top,
    input  logic               isr_found,
    input  logic [NUM_VEC-1:0] irr_vec,
    input  logic [NUM_VEC-1:0] isr_vec,
    input  logic [NUM_VEC-1:0] tmr_vec,
    output logic               move_en,
    output logic [VEC_W-1:0]   move_idx,
    output logic               retire_en,
    output logic [VEC_W-1:0]   retire_idx,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vector,
    output logic               reg_rvalid,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               cpu_irq,
    output logic [VEC_W-1:0]   tpr_o,
    output logic [VEC_W-1:0]   ppr_o,
    output logic [SV_W-1:0]    svr_o,
    output logic [ERR_W-1:0]   err_o
);

    ctl_state_e state_q, state_d;

    logic [VEC_W-1:0]  tpr_q;
    logic [SV_W-1:0]   svr_q;
    logic [ERR_W-1:0]  err_q;
    logic [VEC_W-1:0]  ack_vec_q;
    logic [DATA_W-1:0] rdata_q;

    logic              cmd_ack, cmd_wr, cmd_rd;
    logic              grant;
    logic [CLS_W-1:0]  isr_cls;
    logic [VEC_W-1:0]  ppr;
    rd_sel_e           rsel;
    wr_sel_e           wsel;
    logic [WS_W-1:0]   word_ix;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:SV_W];

    // command arbitration: acknowledge, then write, then read
    assign cmd_ack = (state_q == ST_IDLE) && ack_req;
    assign cmd_wr  = (state_q == ST_IDLE) && !ack_req && reg_wr;
    assign cmd_rd  = (state_q == ST_IDLE) && !ack_req && !reg_wr && reg_rd;

    assign rsel    = rd_decode(reg_idx);
    assign wsel    = wr_decode(reg_idx);
    assign word_ix = reg_idx[WS_W-1:0];

    // processor priority
    assign isr_cls = isr_found ? isr_top[VEC_W-1 -: CLS_W] : '0;
    assign ppr     = (tpr_q[VEC_W-1 -: CLS_W] >= isr_cls) ? tpr_q
                                                          : {isr_cls, {(VEC_W-CLS_W){1'b0}}};

    assign cpu_irq = svr_q[VEC_W] && irr_found &&
                     ((ppr == '0) || (irr_top[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]));

    assign grant = svr_q[VEC_W] && irr_found && !((tpr_q != '0) && (irr_top <= tpr_q));

    assign move_en    = cmd_ack && grant;
    assign move_idx   = irr_top;
    assign retire_en  = cmd_wr && (wsel == WS_EOI) && isr_found;
    assign retire_idx = isr_top;

    always_comb begin
        case (rsel)
            RS_TPR:  rd_mux = DATA_W'(tpr_q);
            RS_PPR:  rd_mux = DATA_W'(ppr);
            RS_SVR:  rd_mux = DATA_W'(svr_q);
            RS_ERR:  rd_mux = DATA_W'(err_q);
            RS_ISR:  rd_mux = isr_vec[int'(word_ix)*DATA_W +: DATA_W];
            RS_TMR:  rd_mux = tmr_vec[int'(word_ix)*DATA_W +: DATA_W];
            RS_IRR:  rd_mux = irr_vec[int'(word_ix)*DATA_W +: DATA_W];
            default: rd_mux = '0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_ack)     state_d = ST_ACK_RESP;
                else if (cmd_rd) state_d = ST_RD_RESP;
            end
            ST_ACK_RESP: state_d = ST_IDLE;
            ST_RD_RESP:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // register file and response holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q     <= '0;
            svr_q     <= SVR_RST;
            err_q     <= '0;
            ack_vec_q <= '0;
            rdata_q   <= '0;
        end else begin
            if (cmd_ack) begin
                ack_vec_q <= grant ? irr_top : svr_q[VEC_W-1:0];
            end
            if (cmd_wr) begin
                case (wsel)
                    WS_TPR:  tpr_q <= reg_wdata[VEC_W-1:0];
                    WS_SVR:  svr_q <= reg_wdata[SV_W-1:0];
                    WS_BAD:  err_q[ERR_BIT] <= 1'b1;
                    default: ;
                endcase
            end
            if (cmd_rd) begin
                rdata_q <= rd_mux;
                if (rsel == RS_NONE) err_q[ERR_BIT] <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ack_valid  = (state_q == ST_ACK_RESP);
        reg_rvalid = (state_q == ST_RD_RESP);
        ack_vector = ack_vec_q;
        reg_rdata  = rdata_q;
    end

    assign tpr_o = tpr_q;
    assign ppr_o = ppr;
    assign svr_o = svr_q;
    assign err_o = err_q;

endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core
    import vpc_pkg::*;
#(
    parameter int VEC_W    = vpc_pkg::VEC_W,
    parameter int DATA_W   = vpc_pkg::DATA_W,
    localparam int NUM_VEC = 1 << VEC_W,
    localparam int WORDS   = NUM_VEC / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_level,
    input  logic              ack_req,
    output logic              ack_valid,
    output logic [VEC_W-1:0]  ack_vector,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IX_W-1:0]   reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rvalid,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cpu_irq
);

    logic [NUM_VEC-1:0] irr_w, isr_w, tmr_w;
    logic [VEC_W-1:0]   irr_top, isr_top;
    logic               irr_found, isr_found;
    logic               move_en, retire_en;
    logic [VEC_W-1:0]   move_idx, retire_idx;
    logic [VEC_W-1:0]   tpr_w, ppr_w;
    logic [VEC_W:0]     svr_w;
    logic [ERR_W-1:0]   err_w;

    vpc_vec_bank #(.VEC_W(VEC_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (req_valid),
        .set_idx    (req_vector),
        .set_level  (req_level),
        .move_en    (move_en),
        .move_idx   (move_idx),
        .retire_en  (retire_en),
        .retire_idx (retire_idx),
        .irr_q      (irr_w),
        .isr_q      (isr_w),
        .tmr_q      (tmr_w)
    );

    vpc_top_bit #(.WORDS(WORDS), .WBITS(DATA_W)) u_irr_top (
        .vec   (irr_w),
        .idx   (irr_top),
        .found (irr_found)
    );

    vpc_top_bit #(.WORDS(WORDS), .WBITS(DATA_W)) u_isr_top (
        .vec   (isr_w),
        .idx   (isr_top),
        .found (isr_found)
    );

    vpc_ctrl #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_req    (ack_req),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_idx    (reg_idx),
        .reg_wdata  (reg_wdata),
        .irr_top    (irr_top),
        .irr_found  (irr_found),
        .isr_top    (isr_top),
        .isr_found  (isr_found),
        .irr_vec    (irr_w),
        .isr_vec    (isr_w),
        .tmr_vec    (tmr_w),
        .move_en    (move_en),
        .move_idx   (move_idx),
        .retire_en  (retire_en),
        .retire_idx (retire_idx),
        .ack_valid  (ack_valid),
        .ack_vector (ack_vector),
        .reg_rvalid (reg_rvalid),
        .reg_rdata  (reg_rdata),
        .cpu_irq    (cpu_irq),
        .tpr_o      (tpr_w),
        .ppr_o      (ppr_w),
        .svr_o      (svr_w),
        .err_o      (err_w)
    );

endmodule

// File: rtl/vpc_chk.sv
module vpc_chk #(
    parameter int VEC_W    = 8,
    localparam int NUM_VEC = 1 << VEC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VEC_W-1:0]   req_vector,
    input logic               req_level,
    input logic               cpu_irq,
    input logic               ack_valid,
    input logic [VEC_W-1:0]   ack_vector,
    input logic               reg_rvalid,
    input logic [NUM_VEC-1:0] irr_q,
    input logic [NUM_VEC-1:0] isr_q,
    input logic [NUM_VEC-1:0] tmr_q,
    input logic [VEC_W-1:0]   tpr,
    input logic [VEC_W-1:0]   ppr,
    input logic [VEC_W:0]     svr,
    input logic [7:0]         err,
    input logic               retire_en
);

    p_req_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> irr_q[$past(req_vector)]);

    p_req_trig_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (tmr_q[$past(req_vector)] == $past(req_level)));

    p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ppr[VEC_W-1 -: 4] >= tpr[VEC_W-1 -: 4]);

    p_irq_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> ((irr_q != '0) && svr[VEC_W]));

    p_ack_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (isr_q[ack_vector] || (ack_vector == svr[VEC_W-1:0])));

    p_eoi_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_en |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err[7] |=> err[7]);

    p_one_response_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_valid && reg_rvalid));

endmodule

bind vec_prio_core vpc_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vector (req_vector),
    .req_level  (req_level),
    .cpu_irq    (cpu_irq),
    .ack_valid  (ack_valid),
    .ack_vector (ack_vector),
    .reg_rvalid (reg_rvalid),
    .irr_q      (irr_w),
    .isr_q      (isr_w),
    .tmr_q      (tmr_w),
    .tpr        (tpr_w),
    .ppr        (ppr_w),
    .svr        (svr_w),
    .err        (err_w),
    .retire_en  (retire_en)
);

// File: tb/vec_prio_core_tb.sv
`timescale 1ns/1ps
module vec_prio_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        req_level = 1'b0;
    logic        ack_req = 1'b0;
    logic        ack_valid;
    logic [7:0]  ack_vector;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [31:0] reg_rdata;
    logic        cpu_irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    // reference model
    logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
    logic [7:0]   m_tpr = '0, m_err = '0;
    logic [8:0]   m_svr = 9'h0FF;

    always #4 clk = ~clk;

    vec_prio_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
    );

    function automatic int top_of(input logic [255:0] v);
        int r = -1;
        for (int i = 0; i < 256; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] m_ppr();
        int t = top_of(m_isr);
        logic [3:0] cls = (t < 0) ? 4'h0 : 4'(t >> 4);
        return (m_tpr[7:4] >= cls) ? m_tpr : {cls, 4'h0};
    endfunction

    function automatic logic m_irq();
        int t = top_of(m_irr);
        logic [7:0] p = m_ppr();
        if (!m_svr[8] || t < 0) return 1'b0;
        return (p == 8'h00) || (4'(t >> 4) > p[7:4]);
    endfunction

    // returns {defined, value}
    function automatic logic [32:0] m_read(input logic [7:0] ix);
        logic [2:0] k = ix[2:0];
        if (ix == 8'h08) return {1'b1, 24'h0, m_tpr};
        if (ix == 8'h0A) return {1'b1, 24'h0, m_ppr()};
        if (ix == 8'h0F) return {1'b1, 23'h0, m_svr};
        if (ix == 8'h28) return {1'b1, 24'h0, m_err};
        if (ix[7:3] == 5'h02) return {1'b1, m_isr[k*32 +: 32]};
        if (ix[7:3] == 5'h03) return {1'b1, m_tmr[k*32 +: 32]};
        if (ix[7:3] == 5'h04) return {1'b1, m_irr[k*32 +: 32]};
        return {1'b0, 32'h0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_irq();
        chk("R3 cpu_irq", {31'h0, cpu_irq}, {31'h0, m_irq()});
    endtask

    task automatic do_req(input logic [7:0] v, input logic lvl);
        @(negedge clk);
        req_valid = 1'b1; req_vector = v; req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        m_irr[v] = 1'b1;
        m_tmr[v] = lvl;
        chk_irq();
    endtask

    task automatic do_ack();
        int t = top_of(m_irr);
        logic gr = m_svr[8] && (t >= 0) && !((m_tpr != 0) && (t <= int'(m_tpr)));
        logic [7:0] exp = gr ? 8'(t) : m_svr[7:0];
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk("R4 ack_valid", {31'h0, ack_valid}, 32'h1);
        chk(gr ? "R4 ack_vector grant" : "R5 ack_vector spurious",
            {24'h0, ack_vector}, {24'h0, exp});
        if (gr) begin
            m_irr[t] = 1'b0;
            m_isr[t] = 1'b1;
        end
        chk_irq();
    endtask

    task automatic do_wr(input logic [7:0] ix, input logic [31:0] d);
        int t;
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = ix; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (ix == 8'h08) m_tpr = d[7:0];
        else if (ix == 8'h0F) m_svr = d[8:0];
        else if (ix == 8'h0B) begin
            t = top_of(m_isr);
            if (t >= 0) m_isr[t] = 1'b0;
        end else if (!m_read(ix)[32]) m_err[7] = 1'b1;
        chk_irq();
    endtask

    task automatic do_rd(input string tag, input logic [7:0] ix);
        logic [32:0] e = m_read(ix);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = ix;
        @(negedge clk);
        reg_rd = 1'b0;
        chk({tag, " rvalid"}, {31'h0, reg_rvalid}, 32'h1);
        chk(e[32] ? tag : "R8 undefined read", reg_rdata, e[31:0]);
        if (!e[32]) m_err[7] = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        chk("R9 cpu_irq after reset", {31'h0, cpu_irq}, 32'h0);
        do_rd("R9 tpr reset", 8'h08);
        do_rd("R9 svr reset", 8'h0F);
        do_rd("R9 err reset", 8'h28);
        do_rd("R9 irr reset", 8'h24);

        // disabled controller: no line, spurious acknowledge (R3, R5)
        do_req(8'h40, 1'b0);
        do_ack();
        do_rd("R5 irr kept after spurious", 8'h22);

        // R7 spurious register mask, then enable
        do_wr(8'h0F, 32'hFFFF_F1F7);
        do_rd("R7 svr mask", 8'h0F);
        do_req(8'h41, 1'b1);
        do_rd("R1 trigger word", 8'h1A);
        do_rd("R1 request word", 8'h22);

        // nesting and R2
        do_ack();
        do_rd("R2 ppr from in-service", 8'h0A);
        do_req(8'h95, 1'b0);
        do_ack();
        do_rd("R4 isr word", 8'h14);
        do_wr(8'h0B, 32'h0);
        do_rd("R6 isr after eoi", 8'h14);
        do_rd("R6 lower isr kept", 8'h12);

        // task priority blocking
        do_wr(8'h08, 32'h58);
        do_rd("R2 ppr from tpr", 8'h0A);
        do_req(8'h55, 1'b0);
        do_ack();
        do_wr(8'h08, 32'h30);
        do_rd("R2 ppr class over tpr", 8'h0A);
        do_ack();

        // R7 read-only writes ignored, R8 undefined access
        do_wr(8'h12, 32'hFFFF_FFFF);
        do_rd("R7 isr write ignored", 8'h12);
        do_wr(8'h0A, 32'hFF);
        do_rd("R7 ppr write ignored", 8'h0A);
        do_rd("R8 err clean", 8'h28);
        do_rd("R8", 8'h0B);
        do_rd("R8 err set", 8'h28);
        do_wr(8'h31, 32'h1);
        do_rd("R8 err sticky", 8'h28);

        // drain in-service, empty eoi and empty acknowledge
        repeat (4) do_wr(8'h0B, 32'h0);
        do_rd("R6 isr empty", 8'h12);
        do_wr(8'h08, 32'h0);
        while (top_of(m_irr) >= 0) do_ack();
        do_ack();

        // random phase over a narrow vector band
        for (int n = 0; n < 4000; n++) begin
            int op = int'($urandom % 12);
            case (op)
                0, 1, 2, 3: do_req(8'h20 + 8'($urandom % 96), 1'($urandom));
                4, 5, 6:    do_ack();
                7:          do_wr(8'h0B, $urandom);
                8:          do_wr(8'h08, ($urandom % 2) ? 32'h0 : {24'h0, 8'h20 + 8'($urandom % 96)});
                9:          do_wr(8'h0F, {23'h0, ($urandom % 8) != 0, 8'($urandom)});
                10:         do_rd("R7 random bank read", 8'h10 + 8'($urandom % 24));
                default:    do_rd("R2 random ppr read", 8'h0A);
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule